// File: doc/BRIEF.md
# Character Bank Switch with Work RAM Gating

This block is a slice of a cartridge mapper. It holds two character bank registers and uses the PPU's address bit 12 to choose between them. That gives two 4 KB windows of character memory that software can switch independently. The chosen register drives the five upper character address lines, character A12 through A16.

The top output bit, character A16, also serves as the active-low chip enable of the work RAM on the CPU side. This means PPU fetch activity switches CPU-visible RAM on and off. Software can exploit this on purpose. It loads the first register with 0x00 and the second with 0x10, so the RAM enable tracks PPU A12. It then tells enabled RAM from open bus by reading a value back through the RAM window.

Bank registers load through a direct parallel write port. While the RAM is disabled, a CPU read returns the last value seen on the CPU data bus, and a flag marks the read as open bus.

Top module: `chr_bank_wram_gate`

## Requirements
- R1: After reset both bank registers are zero, so `chr_hi` is 0 and `ram_ce_n` is 0 for either level of `ppu_a12`.
- R2: With `ppu_a12` low, `chr_hi` equals the register last written with `reg_sel`=0.
- R3: With `ppu_a12` high, `chr_hi` equals the register last written with `reg_sel`=1.
- R4: A change on `ppu_a12` reaches `chr_hi` and `ram_ce_n` in the same cycle, with no clock edge in between.
- R5: `ram_ce_n` is active low and always equals bit 4 (the top bit) of `chr_hi`.
- R6: With 0x00 in the `reg_sel`=0 register and 0x10 in the `reg_sel`=1 register, `ram_ce_n` equals `ppu_a12`.
- R7: A read (`cpu_ram_cs`=1, `cpu_we`=0) while `ram_ce_n` is 0 returns the value most recently stored at `cpu_addr`, and `cpu_open_bus` is 0.
- R8: A read while `ram_ce_n` is 1 raises `cpu_open_bus` and returns the open-bus value instead of stored data.
- R9: A write (`cpu_ram_cs`=1, `cpu_we`=1) while `ram_ce_n` is 1 leaves the RAM contents unchanged.
- R10: The open-bus value is the last value on the CPU data bus: the data of the last write to the window (whether or not it was stored), or the data returned by the last read, whichever came later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Bank register write strobe |
| reg_sel | input | 1 | 0 picks the A12-low register, 1 the A12-high register |
| reg_wdata | input | BANK_W | Bank register write value |
| ppu_a12 | input | 1 | PPU address bit 12 |
| chr_hi | output | BANK_W | Character address lines A12..A16 |
| ram_ce_n | output | 1 | Work RAM chip enable, active low |
| cpu_ram_cs | input | 1 | CPU access to the work RAM window |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | AW | Work RAM word address |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | Stored data when enabled, open-bus value when disabled |
| cpu_open_bus | output | 1 | High during a read of disabled RAM |

## Verification
The bench builds the block with BANK_W=5, DW=8 and AW=4. The 16-word RAM makes random accesses hit the same addresses often. Reads after enabled writes, ignored writes and open-bus reads therefore follow each other within a few operations. Random register values reach both states of the top bank bit, so the RAM enable changes both with `ppu_a12` and with register writes.

// File: rtl/chr_bank_wram_gate.sv
module chr_bank_wram_gate #(
  parameter int BANK_W = 5,
  parameter int AW     = 6,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [BANK_W-1:0] reg_wdata,
  input  logic              ppu_a12,
  output logic [BANK_W-1:0] chr_hi,
  output logic              ram_ce_n,
  input  logic              cpu_ram_cs,
  input  logic              cpu_we,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic              cpu_open_bus
);
  localparam int DEPTH = 1 << AW;

  logic [BANK_W-1:0] bank_lo, bank_hi;
  logic [DW-1:0]     mem [DEPTH];
  logic [DW-1:0]     bus_q;
  logic              ram_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_lo <= '0;
      bank_hi <= '0;
    end else if (reg_we) begin
      if (reg_sel) bank_hi <= reg_wdata;
      else         bank_lo <= reg_wdata;
    end
  end

  assign chr_hi   = ppu_a12 ? bank_hi : bank_lo;
  assign ram_ce_n = chr_hi[BANK_W-1];
  assign ram_on   = cpu_ram_cs && !ram_ce_n;

  always_ff @(posedge clk) begin
    if (ram_on && cpu_we) mem[cpu_addr] <= cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          bus_q <= '0;
    else if (cpu_ram_cs) bus_q <= cpu_we ? cpu_wdata : cpu_rdata;
  end

  assign cpu_rdata    = ram_ce_n ? bus_q : mem[cpu_addr];
  assign cpu_open_bus = cpu_ram_cs && !cpu_we && ram_ce_n;
endmodule

// File: rtl/chr_bank_wram_gate_chk.sv
module chr_bank_wram_gate_chk #(
  parameter int BANK_W = 5,
  parameter int AW     = 6,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              reg_sel,
  input logic [BANK_W-1:0] reg_wdata,
  input logic              ppu_a12,
  input logic [BANK_W-1:0] chr_hi,
  input logic              ram_ce_n,
  input logic              cpu_ram_cs,
  input logic              cpu_we,
  input logic [AW-1:0]     cpu_addr,
  input logic [DW-1:0]     cpu_wdata,
  input logic [DW-1:0]     cpu_rdata,
  input logic              cpu_open_bus
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (chr_hi == '0 && !ram_ce_n)); // R1

  AST_LOW_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_sel) |=> (ppu_a12 || chr_hi == $past(reg_wdata))); // R2

  AST_HIGH_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel) |=> (!ppu_a12 || chr_hi == $past(reg_wdata))); // R3

  AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ram_cs && cpu_we && !ram_ce_n) |=>
    (!(cpu_ram_cs && !cpu_we && !ram_ce_n && cpu_addr == $past(cpu_addr))
     || cpu_rdata == $past(cpu_wdata))); // R7

  AST_OPEN_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_open_bus && $past(cpu_open_bus)) |-> $stable(cpu_rdata)); // R8

  AST_OPEN_BUS_LAST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ram_cs && cpu_we) |=> (!cpu_open_bus || cpu_rdata == $past(cpu_wdata))); // R10
endmodule

bind chr_bank_wram_gate chr_bank_wram_gate_chk #(.BANK_W(BANK_W), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .ppu_a12(ppu_a12), .chr_hi(chr_hi), .ram_ce_n(ram_ce_n), .cpu_ram_cs(cpu_ram_cs),
  .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
  .cpu_open_bus(cpu_open_bus)
);

// File: tb/chr_bank_wram_gate_bench.sv
`timescale 1ns/1ps
module chr_bank_wram_gate_bench;
  localparam int BANK_W = 5;
  localparam int AW     = 4;
  localparam int DW     = 8;
  localparam int DEPTH  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_we, reg_sel, ppu_a12, cpu_ram_cs, cpu_we, cpu_open_bus, ram_ce_n;
  logic [BANK_W-1:0] reg_wdata, chr_hi;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;

  always #2 clk = ~clk;

  chr_bank_wram_gate #(.BANK_W(BANK_W), .AW(AW), .DW(DW)) u_chr_bank_wram_gate (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ppu_a12(ppu_a12), .chr_hi(chr_hi), .ram_ce_n(ram_ce_n), .cpu_ram_cs(cpu_ram_cs),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_open_bus(cpu_open_bus)
  );

  int tests = 0;
  int fails = 0;

  logic [BANK_W-1:0] m_lo, m_hi;
  logic [DW-1:0]     m_mem [DEPTH];
  logic [DW-1:0]     m_bus;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [BANK_W-1:0] exp_chr(input logic a12);
    return a12 ? m_hi : m_lo;
  endfunction

  task automatic step(input string rtag, input logic rwe, input logic rsel,
                      input logic [BANK_W-1:0] rwd, input logic a12, input logic cs,
                      input logic we, input logic [AW-1:0] addr, input logic [DW-1:0] wd);
    logic [BANK_W-1:0] ec;
    logic [DW-1:0] er;
    @(negedge clk);
    reg_we = rwe; reg_sel = rsel; reg_wdata = rwd; ppu_a12 = a12;
    cpu_ram_cs = cs; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    #1;
    ec = exp_chr(a12);
    check(a12 ? "R3 high-bank select" : "R2 low-bank select", 32'(chr_hi), 32'(ec));
    check("R5 ce_n is top bank bit", 32'(ram_ce_n), 32'(ec[BANK_W-1]));
    if (cs && !we) begin
      er = ec[BANK_W-1] ? m_bus : m_mem[addr];
      check({rtag, " read data"}, 32'(cpu_rdata), 32'(er));
      check({rtag, " open-bus flag"}, 32'(cpu_open_bus), 32'(ec[BANK_W-1]));
    end
    @(posedge clk);
    if (cs) begin
      if (we) begin
        if (!ec[BANK_W-1]) m_mem[addr] = wd;
        m_bus = wd;
      end else begin
        m_bus = ec[BANK_W-1] ? m_bus : m_mem[addr];
      end
    end
    if (rwe) begin
      if (rsel) m_hi = rwd; else m_lo = rwd;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_we = 0; reg_sel = 0; reg_wdata = '0; ppu_a12 = 0;
    cpu_ram_cs = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    m_lo = '0; m_hi = '0; m_bus = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 reset low bank", 32'(chr_hi), 0);
    check("R1 reset ce_n", 32'(ram_ce_n), 0);
    ppu_a12 = 1; #1;
    check("R1 reset high bank", 32'(chr_hi), 0);
    check("R1 reset ce_n a12 high", 32'(ram_ce_n), 0);

    for (int i = 0; i < DEPTH; i++)
      step("R7", 0, 0, '0, i[0], 1, 1, AW'(i), DW'(8'h30 + i));
    for (int i = 0; i < DEPTH; i++)
      step("R7 enabled", 0, 0, '0, 0, 1, 0, AW'(i), '0);

    step("R2", 1, 0, 5'h00, 0, 0, 0, '0, '0);
    step("R3", 1, 1, 5'h10, 0, 0, 0, '0, '0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ppu_a12 = i[0]; #1;
      check("R6 ce_n follows a12", 32'(ram_ce_n), 32'(i[0]));
      check("R4 same-cycle chr_hi", 32'(chr_hi), i[0] ? 32'h10 : 32'h00);
    end

    step("R7", 0, 0, '0, 0, 1, 1, AW'(3), 8'hA5);
    step("R7 enabled", 0, 0, '0, 0, 1, 0, AW'(3), '0);
    step("R8 disabled", 0, 0, '0, 1, 1, 0, AW'(3), '0);
    step("R9", 0, 0, '0, 1, 1, 1, AW'(3), 8'h5A);
    step("R10 open bus after ignored write", 0, 0, '0, 1, 1, 0, AW'(7), '0);
    step("R9 contents kept", 0, 0, '0, 0, 1, 0, AW'(3), '0);
    step("R10 open bus after enabled read", 0, 0, '0, 1, 1, 0, AW'(0), '0);

    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: step("R2/R3", 1, 1'($urandom), BANK_W'($urandom), 1'($urandom), 0, 0, '0, '0);
        1: step("R9", 0, 0, '0, 1'($urandom), 1, 1, AW'($urandom), DW'($urandom));
        2: step("R7/R8", 0, 0, '0, 1'($urandom), 1, 0, AW'($urandom), '0);
        default: step("R4", 0, 0, '0, 1'($urandom), 0, 0, '0, '0);
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule